// File: doc/BRIEF.md
# Program RAM Loader Front End

This block sits in front of a 256-byte program RAM that an operator fills by hand and a small CPU later runs from. A mode switch selects between two owners of the RAM. In program mode, a manual 8-bit address and a manual 8-bit data value are presented, and a push-button stores the data at that address. In run mode, the CPU memory address register supplies the address. The RAM then talks to the shared CPU bus through a bidirectional buffer, and the enable and direction of that buffer come from the control word of the current microstep.

The bidirectional buffer is modelled as a split bus: `bus_i` carries bus data into the RAM, and `bus_o` is qualified by `bus_drive_o`. The mode switch and the button are asynchronous inputs, so each passes through its own synchronizer. Each button press is reduced to a single write pulse. While programming, the CPU clock enable is held low. The RAM has no reset, so its contents must be loaded again after power-up. Location 0 cannot be written by hand: the CPU increments its program counter before the first fetch, so program lines start at address 1 and at most 255 of them can be entered.

Top module: `memload_frontend`

## Requirements
- R1: `ram_addr_o` equals `man_addr_i` while the synchronized mode is program, and `mar_i` while it is run.
- R2: In program mode, a rising edge on `wr_btn_i` stores `man_data_i` at `man_addr_i` for every address from 1 to 255.
- R3: A press held for many cycles writes exactly once. A change to `man_data_i` while the button stays held does not alter the stored byte.
- R4: A manual press at address 0 leaves location 0 unchanged.
- R5: In run mode with `bus_oe_i`=1 and `bus_dir_i`=1, `bus_drive_o` is 1 and `bus_o` shows the byte stored at `mar_i`.
- R6: In run mode with `bus_oe_i`=1 and `bus_dir_i`=0, the byte on `bus_i` is stored at `mar_i` on the clock edge, and `bus_drive_o` stays 0. With `bus_oe_i`=0, the RAM neither drives the bus nor stores anything.
- R7: In program mode, `bus_drive_o` is 0 and `bus_o` is 0 for every setting of `bus_oe_i` and `bus_dir_i`, and CPU-side writes store nothing.
- R8: In run mode, a button press stores nothing.
- R9: `prog_led_o` is 1 and `cpu_clk_en_o` is 0 in program mode, and the reverse holds in run mode. A change on `prog_mode_i` shows on both outputs after exactly two rising clock edges.
- R10: While `rst_ni` is low, the block is in program mode: `prog_led_o`=1, `cpu_clk_en_o`=0 and `bus_drive_o`=0, whatever the level of `prog_mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_mode_i | input | 1 | Mode switch, asynchronous (1 = program, 0 = run) |
| man_addr_i | input | 8 | Manual address |
| man_data_i | input | 8 | Manual data |
| wr_btn_i | input | 1 | Write button, asynchronous, active high |
| mar_i | input | 8 | CPU memory address register |
| bus_oe_i | input | 1 | Buffer enable from the control word |
| bus_dir_i | input | 1 | Buffer direction (1 = RAM to bus, 0 = bus to RAM) |
| bus_i | input | 8 | Shared bus data into the RAM |
| bus_o | output | 8 | RAM data toward the bus, 0 when not driving |
| bus_drive_o | output | 1 | Buffer drives the bus |
| ram_addr_o | output | 8 | Address applied to the RAM |
| prog_led_o | output | 1 | Program mode indicator |
| cpu_clk_en_o | output | 1 | CPU clock enable |

## Verification
The hardest case to reach is a CPU-side write attempted in program mode. It can only be seen later, through a run-mode read of the same location. The stimulus therefore sweeps every address in program mode with the buffer enabled and the bus carrying a byte different from the one stored, then switches to run mode and reads all 256 locations back. The single-write rule is handled the same way: the manual data changes while the button is still held, and a later readback shows which byte was kept. Protection of location 0 is also shown through readback, of a value that only a run-mode CPU write could have placed there.

// File: rtl/memload_pkg.sv
package memload_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_PROG = 1'b1
  } mode_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/press_pulse.sv
module press_pulse #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic pulse_o
);
  logic btn_s, btn_last_q;

  bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (btn_i),
    .q_o   (btn_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) btn_last_q <= 1'b0;
    else         btn_last_q <= btn_s;

  // one cycle per press, however long held
  assign pulse_o = btn_s & ~btn_last_q;
endmodule

// File: rtl/prog_ram.sv
module prog_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  // volatile: no reset, contents lost at power-off
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem_q[addr_i] <= wdata_i;

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/memload_frontend.sv
module memload_frontend
  import memload_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_mode_i,
  input  logic [ADDR_W-1:0] man_addr_i,
  input  logic [DATA_W-1:0] man_data_i,
  input  logic              wr_btn_i,
  input  logic [ADDR_W-1:0] mar_i,
  input  logic              bus_oe_i,
  input  logic              bus_dir_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_drive_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              prog_led_o,
  output logic              cpu_clk_en_o
);
  localparam logic [ADDR_W-1:0] RSVD_ADDR = '0;

  logic              mode_s;
  mode_e             mode;
  logic              wr_pulse;
  logic              man_wr, cpu_wr, ram_we;
  logic [DATA_W-1:0] ram_wd, ram_rd;

  // reset into program mode: bus released, CPU clock held
  bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mode_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (prog_mode_i),
    .q_o   (mode_s)
  );
  assign mode = mode_e'(mode_s);

  press_pulse #(.STAGES(SYNC_STAGES)) u_press (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (wr_btn_i),
    .pulse_o(wr_pulse)
  );

  always_comb begin
    ram_addr_o = (mode == MODE_PROG) ? man_addr_i : mar_i;
    // location 0 is skipped by the first fetch; keep it out of manual entry
    man_wr     = (mode == MODE_PROG) && wr_pulse && (man_addr_i != RSVD_ADDR);
    cpu_wr     = (mode == MODE_RUN) && bus_oe_i && !bus_dir_i;
    ram_we     = man_wr | cpu_wr;
    ram_wd     = (mode == MODE_PROG) ? man_data_i : bus_i;
  end

  prog_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .addr_i (ram_addr_o),
    .wdata_i(ram_wd),
    .rdata_o(ram_rd)
  );

  assign bus_drive_o  = (mode == MODE_RUN) && bus_oe_i && bus_dir_i;
  assign bus_o        = bus_drive_o ? ram_rd : '0;
  assign prog_led_o   = (mode == MODE_PROG);
  assign cpu_clk_en_o = (mode == MODE_RUN);
endmodule

// File: rtl/memload_chk.sv
module memload_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog_led_o,
  input logic              cpu_clk_en_o,
  input logic              bus_drive_o,
  input logic              bus_oe_i,
  input logic              bus_dir_i,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic [ADDR_W-1:0] mar_i,
  input logic [ADDR_W-1:0] man_addr_i,
  input logic              wr_pulse
);
  AST_ADDR_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_led_o |-> ram_addr_o == mar_i); // R1
  AST_ADDR_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_led_o |-> ram_addr_o == man_addr_i); // R1
  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse |=> !wr_pulse); // R3
  AST_DRIVE_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_drive_o |-> bus_oe_i && bus_dir_i); // R5
  AST_NO_DRIVE_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_led_o |-> !bus_drive_o); // R7
  AST_CLK_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_led_o != cpu_clk_en_o); // R9
endmodule

bind memload_frontend memload_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .prog_led_o  (prog_led_o),
  .cpu_clk_en_o(cpu_clk_en_o),
  .bus_drive_o (bus_drive_o),
  .bus_oe_i    (bus_oe_i),
  .bus_dir_i   (bus_dir_i),
  .ram_addr_o  (ram_addr_o),
  .mar_i       (mar_i),
  .man_addr_i  (man_addr_i),
  .wr_pulse    (wr_pulse)
);

// File: tb/memload_frontend_tb_top.sv
module memload_frontend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       prog_mode_i;
  logic [7:0] man_addr_i, man_data_i, mar_i, bus_i;
  logic       wr_btn_i, bus_oe_i, bus_dir_i;
  logic [7:0] bus_o, ram_addr_o;
  logic       bus_drive_o, prog_led_o, cpu_clk_en_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  memload_frontend dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_mode_i (prog_mode_i),
    .man_addr_i  (man_addr_i),
    .man_data_i  (man_data_i),
    .wr_btn_i    (wr_btn_i),
    .mar_i       (mar_i),
    .bus_oe_i    (bus_oe_i),
    .bus_dir_i   (bus_dir_i),
    .bus_i       (bus_i),
    .bus_o       (bus_o),
    .bus_drive_o (bus_drive_o),
    .ram_addr_o  (ram_addr_o),
    .prog_led_o  (prog_led_o),
    .cpu_clk_en_o(cpu_clk_en_o)
  );

  function automatic logic [7:0] man_val(int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  function automatic logic [7:0] cpu_val(int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic m);
    @(negedge clk_i);
    bus_oe_i    = 1'b0;
    prog_mode_i = m;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic press(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    man_addr_i = a;
    man_data_i = d;
    wr_btn_i   = 1'b1;
    repeat (4) @(negedge clk_i);
    wr_btn_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic cpu_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    mar_i     = a;
    bus_i     = d;
    bus_oe_i  = 1'b1;
    bus_dir_i = 1'b0;
    #1;
    chk("R6 no drive on write", 32'(bus_drive_o), 32'd0);
    @(negedge clk_i);
    bus_oe_i = 1'b0;
  endtask

  task automatic cpu_read(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk_i);
    mar_i     = a;
    bus_oe_i  = 1'b1;
    bus_dir_i = 1'b1;
    #1;
    chk(req, 32'(bus_drive_o), 32'd1);
    chk(req, 32'(bus_o), 32'(exp));
    bus_oe_i = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; prog_mode_i = 1'b0; man_addr_i = '0; man_data_i = '0;
    wr_btn_i = 1'b0; mar_i = '0; bus_oe_i = 1'b1; bus_dir_i = 1'b1; bus_i = '0;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 led", 32'(prog_led_o), 32'd1);
    chk("R10 clk_en", 32'(cpu_clk_en_o), 32'd0);
    chk("R10 drive", 32'(bus_drive_o), 32'd0);
    bus_oe_i = 1'b0;
    rst_ni = 1'b1;
    // R9 two-edge latency toward run
    @(negedge clk_i);
    chk("R9 one edge", 32'(prog_led_o), 32'd1);
    @(negedge clk_i);
    chk("R9 two edges led", 32'(prog_led_o), 32'd0);
    chk("R9 two edges clk_en", 32'(cpu_clk_en_o), 32'd1);

    // seed location 0 from the CPU side
    cpu_write(8'h00, 8'hC3);

    set_mode(1'b1);
    chk("R9 prog led", 32'(prog_led_o), 32'd1);
    chk("R9 prog clk_en", 32'(cpu_clk_en_o), 32'd0);
    for (int a = 0; a < 256; a++) begin
      mar_i = 8'(255 - a);
      press(8'(a), man_val(a));
      chk("R1 prog addr", 32'(ram_addr_o), 32'(a));
    end

    set_mode(1'b0);
    for (int a = 0; a < 256; a++) begin
      man_addr_i = 8'(~a);
      @(negedge clk_i);
      mar_i = 8'(a);
      #1;
      chk("R1 run addr", 32'(ram_addr_o), 32'(a));
    end
    cpu_read("R4 addr0 kept", 8'h00, 8'hC3);
    for (int a = 1; a < 256; a++)
      cpu_read("R2 manual store", 8'(a), man_val(a));

    // R3 long hold, data changes mid-press
    set_mode(1'b1);
    @(negedge clk_i);
    man_addr_i = 8'h07; man_data_i = 8'h77; wr_btn_i = 1'b1;
    repeat (4) @(negedge clk_i);
    man_data_i = 8'h99;
    repeat (6) @(negedge clk_i);
    wr_btn_i = 1'b0;
    repeat (3) @(negedge clk_i);
    set_mode(1'b0);
    cpu_read("R3 single write", 8'h07, 8'h77);

    // R6 CPU writes, with disabled-buffer cycles between
    for (int a = 0; a < 256; a++) begin
      cpu_write(8'(a), cpu_val(a));
      @(negedge clk_i);
      mar_i = 8'(a); bus_i = 8'hFF; bus_oe_i = 1'b0; bus_dir_i = 1'(a & 1);
      #1;
      chk("R6 oe low no drive", 32'(bus_drive_o), 32'd0);
    end
    for (int a = 0; a < 256; a++)
      cpu_read("R6 cpu store", 8'(a), cpu_val(a));

    // R7 program mode: no drive, CPU writes ignored
    set_mode(1'b1);
    for (int a = 0; a < 256; a++) begin
      for (int d = 0; d < 2; d++) begin
        @(negedge clk_i);
        mar_i = 8'(a); man_addr_i = 8'(a); bus_i = ~cpu_val(a);
        bus_oe_i = 1'b1; bus_dir_i = 1'(d);
        #1;
        chk("R7 no drive", 32'(bus_drive_o), 32'd0);
        chk("R7 bus zero", 32'(bus_o), 32'd0);
      end
    end
    set_mode(1'b0);
    for (int a = 0; a < 256; a++)
      cpu_read("R7 cpu write ignored", 8'(a), cpu_val(a));

    // R8 button ignored in run mode
    mar_i = 8'h05;
    press(8'h05, 8'hEE);
    cpu_read("R8 run press ignored", 8'h05, cpu_val(5));

    // R9 latency toward program
    @(negedge clk_i);
    prog_mode_i = 1'b1;
    @(negedge clk_i);
    chk("R9 one edge run", 32'(cpu_clk_en_o), 32'd1);
    @(negedge clk_i);
    chk("R9 two edges prog", 32'(cpu_clk_en_o), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule